// File: doc/BRIEF.md
# Manchester Command Receiver and Access Controller

This block sits beside the frame sequencer of a low-frequency transponder and takes over while the reader is allowed to talk: the listening window that follows each identity transmission. It watches a demodulated field-level input (`field_mod`, 1 while the reader modulates), locks onto a command whose first modulation edge falls inside the legal part of the window, and decodes Manchester bits at the receive bit rate taken from the configuration word. Each command starts with a 6-bit opcode. Data-carrying commands add 32 data bits and one even-parity bit.

Once a command is fully received, the block applies the protection rules: parity, the fixed alternating filler in lock and configuration updates, page locks, the permanent lock on the serial-number page, the password latch, and the rule that a page write must come before any lock update. A command that passes produces a page write request to the memory model. After the memory reports completion, the block asks the sequencer to answer with the affected page. A read asks for its page directly. Every failure produces a one-cycle return-to-identity pulse and leaves memory untouched. A disable command silences the block until reset.

Top module: `crx_cmd_ctrl`

## Requirements
- R1: A receive bit with modulation in its first half and none in its second half decodes as 0. The opposite decodes as 1. A bit whose halves are equal aborts the command with an `id_ret` pulse, and no response or write follows.
- R2: The transmit bit period is (cfg_word[13:8]+1)·TX_UNIT clocks. The receive bit period is twice that when cfg_word[7]=0 and four times that when cfg_word[7]=1.
- R3: The window opens on `win_start`. It spans 8 transmit bit times, numbered 0 to 7. A command is accepted only if its first modulation falls within bit times 1 to 6. Modulation in bit time 0 or 7 produces no output at all.
- R4: Opcodes, first bit received leftmost: 0AAA10 writes page AAA, 0AAA01 reads page AAA, 000011 updates locks, 010011 writes configuration, 000111 writes the password, 011000 disables, and 011100 checks the password. Any other code aborts with `id_ret`.
- R5: Data commands carry 39 bits (opcode, data with MSB first, parity). The count of ones across them must be even. Otherwise the command aborts and memory is not written.
- R6: A page write to page A (0..6) whose lock bit cfg_word[24+A] is clear issues one `mem_wr` to page A. After `mem_wr_done`, it pulses `resp_req` with `resp_page`=A. Writes to page 7, or to a locked page, abort.
- R7: A lock update is refused unless a page write has succeeded since reset. Its low 24 data bits must be 0x555555. The page 8 value written is {old lock byte OR new byte, old cfg_word[23:0]}, so no lock bit ever clears. The response page is 8.
- R8: A configuration write needs the top data byte to equal 0x55 and cfg_word[0] to be clear. It writes {old lock byte, new 24 bits} to page 8 and responds with page 8.
- R9: While cfg_word[14] is set, every read and write command aborts until a password check matches `pw_word`. The check always ends with `id_ret`. A match sets a latch that only reset clears. A mismatch leaves access refused.
- R10: A password write is refused while cfg_word[1] is set. Otherwise it writes page 9 and finishes with `id_ret` and no response, so page 9 is never sent out.
- R11: A read of page A (0..7) pulses `resp_req` with `resp_page`=A one receive bit time after the opcode, with no `id_ret`. `resp_page` is never 9.
- R12: The disable command sets `cmd_off`, which holds until reset. While it is set, windows are ignored and no write, response or abort is produced.
- R13: After reset all outputs are low. `mem_wr`, `resp_req` and `id_ret` are single-cycle pulses and never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock |
| rst | input | 1 | Synchronous active-high reset |
| win_start | input | 1 | One-cycle pulse opening a listening window |
| field_mod | input | 1 | Demodulated field level, 1 while the reader modulates |
| cfg_word | input | 32 | Current page 8 contents (locks and options) |
| pw_word | input | 32 | Current page 9 contents (password) |
| mem_wr_done | input | 1 | Memory model finished the requested write |
| mem_wr | output | 1 | One-cycle page write request |
| mem_wr_page | output | 4 | Page index of the write |
| mem_wr_data | output | 32 | Word to write |
| resp_req | output | 1 | One-cycle request to transmit a page |
| resp_page | output | 4 | Page to transmit |
| id_ret | output | 1 | One-cycle return-to-identity pulse (abort or check done) |
| cmd_off | output | 1 | Block disabled until reset |

## Verification
The assertions assume that `field_mod` is already synchronous to `clk`, and that `cfg_word` changes only through writes this block requests. They also assume `mem_wr_done` arrives only after a `mem_wr`. The bench drives the field on falling edges, in whole half-bit runs at exactly the configured rate. Its memory model applies each write on the request and returns completion three cycles later. The bench never changes page 8 behind the block's back.

// File: rtl/crx_pkg.sv
package crx_pkg;

    // Page 8 field positions that the controller decodes
    localparam int CFG_LOCK_LSB = 24;
    localparam int CFG_PWON     = 14;
    localparam int CFG_TCLK_LSB = 8;
    localparam int CFG_RX4      = 7;
    localparam int CFG_PWLK     = 1;
    localparam int CFG_CFGLK    = 0;

    localparam logic [3:0]  PG_SERIAL = 4'd7;
    localparam logic [3:0]  PG_CFG    = 4'd8;
    localparam logic [3:0]  PG_PW     = 4'd9;
    localparam logic [23:0] FILL_LO   = 24'h555555;
    localparam logic [7:0]  FILL_HI   = 8'h55;

    localparam int OP_BITS  = 6;
    localparam int CMD_BITS = 39;

    typedef enum logic [2:0] {
        K_BAD, K_WRPAGE, K_RDPAGE, K_WRLOCK, K_WRCFG, K_WRPW, K_DIS, K_CHKPW
    } cmd_kind_e;

    typedef enum logic [1:0] {C_IDLE, C_RX, C_GAP, C_WR} ctl_state_e;

    function automatic cmd_kind_e op_kind(input logic [5:0] op);
        cmd_kind_e k;
        if (op[5])                 k = K_BAD;
        else if (op[1:0] == 2'b10) k = K_WRPAGE;
        else if (op[1:0] == 2'b01) k = K_RDPAGE;
        else begin
            case (op)
                6'b000011: k = K_WRLOCK;
                6'b010011: k = K_WRCFG;
                6'b000111: k = K_WRPW;
                6'b011000: k = K_DIS;
                6'b011100: k = K_CHKPW;
                default:   k = K_BAD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/crx_bit_decoder.sv
module crx_bit_decoder #(
    parameter int TX_UNIT = 16,
    parameter int TCLK_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_start,
    input  logic              field_mod,
    input  logic [TCLK_W-1:0] tclk,
    input  logic              rx_x4,
    input  logic              keep,
    output logic              start_det,
    output logic              bit_stb,
    output logic              bit_val,
    output logic              bit_err,
    output logic              bit_end
);
    localparam int TX_MAX = (1 << TCLK_W) * TX_UNIT;
    localparam int CNT_W  = $clog2(TX_MAX * 4) + 1;

    logic [CNT_W-1:0] tx_len, rx_len, q_pt, q3_pt;
    logic [CNT_W-1:0] tcnt, cnt;
    logic [2:0]       tbit;
    logic             win_on, rx_on, first_half;

    always_comb begin
        tx_len = CNT_W'((32'(tclk) + 32'd1) * 32'(TX_UNIT));
        rx_len = rx_x4 ? (tx_len << 2) : (tx_len << 1);
        q_pt   = rx_len >> 2;
        q3_pt  = q_pt + (rx_len >> 1);
    end

    assign start_det = win_on && field_mod && (tbit >= 3'd1) && (tbit <= 3'd6);
    assign bit_stb   = rx_on && keep && (cnt == q3_pt);
    assign bit_val   = field_mod;
    assign bit_err   = bit_stb && (first_half == field_mod);
    assign bit_end   = rx_on && keep && (cnt == rx_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_on     <= 1'b0;
            tcnt       <= '0;
            tbit       <= '0;
            rx_on      <= 1'b0;
            cnt        <= '0;
            first_half <= 1'b0;
        end else begin
            if (win_start && !rx_on) begin
                win_on <= 1'b1;
                tcnt   <= '0;
                tbit   <= '0;
            end else if (start_det) begin
                win_on <= 1'b0;
            end else if (win_on) begin
                if (tcnt == tx_len - 1'b1) begin
                    tcnt <= '0;
                    if (tbit == 3'd6) win_on <= 1'b0;
                    else              tbit   <= tbit + 3'd1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end

            if (start_det) begin
                rx_on <= 1'b1;
                cnt   <= CNT_W'(1);
            end else if (rx_on && !keep) begin
                rx_on <= 1'b0;
            end else if (rx_on) begin
                cnt <= (cnt == rx_len - 1'b1) ? '0 : cnt + 1'b1;
                if (cnt == q_pt) first_half <= field_mod;
            end
        end
    end
endmodule

// File: rtl/crx_access.sv
module crx_access
    import crx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_det,
    input  logic        bit_stb,
    input  logic        bit_val,
    input  logic        bit_err,
    input  logic        bit_end,
    input  logic [31:0] cfg_word,
    input  logic [31:0] pw_word,
    input  logic        mem_wr_done,
    output logic        keep,
    output logic        mem_wr,
    output logic [3:0]  mem_wr_page,
    output logic [31:0] mem_wr_data,
    output logic        resp_req,
    output logic [3:0]  resp_page,
    output logic        id_ret,
    output logic        cmd_off
);
    ctl_state_e          st;
    logic [CMD_BITS-1:0] sh, sh_n;
    logic [5:0]          nbits, nb;
    logic                pw_ok, wrote, resp_after, gap_n;
    logic [3:0]          page_q;

    cmd_kind_e   kind6, kind;
    logic [5:0]  op;
    logic [31:0] dat;
    logic [7:0]  lock_b;
    logic        gate, par_ok, pg_locked;
    logic        fin_wr, fin_resp, fin_pw_ok;
    logic [3:0]  fin_page;
    logic [31:0] fin_data;

    assign keep = (st == C_RX) || (st == C_GAP);

    always_comb begin
        sh_n      = {sh[CMD_BITS-2:0], bit_val};
        nb        = nbits + 6'd1;
        kind6     = op_kind(sh_n[5:0]);
        op        = sh_n[CMD_BITS-1 -: OP_BITS];
        kind      = op_kind(op);
        dat       = sh_n[32:1];
        lock_b    = cfg_word[CFG_LOCK_LSB +: 8];
        gate      = !cfg_word[CFG_PWON] || pw_ok;
        par_ok    = ~^sh_n;
        pg_locked = lock_b[op[4:2]] || ({1'b0, op[4:2]} == PG_SERIAL);

        fin_wr    = 1'b0;
        fin_resp  = 1'b1;
        fin_pw_ok = 1'b0;
        fin_page  = PG_CFG;
        fin_data  = dat;
        if (par_ok) begin
            case (kind)
                K_WRPAGE: begin
                    fin_page = {1'b0, op[4:2]};
                    fin_wr   = gate && !pg_locked;
                end
                K_WRLOCK: begin
                    fin_data = {lock_b | dat[31:24], cfg_word[23:0]};
                    fin_wr   = gate && wrote && (dat[23:0] == FILL_LO);
                end
                K_WRCFG: begin
                    fin_data = {lock_b, dat[23:0]};
                    fin_wr   = gate && !cfg_word[CFG_CFGLK] && (dat[31:24] == FILL_HI);
                end
                K_WRPW: begin
                    fin_page = PG_PW;
                    fin_resp = 1'b0;
                    fin_wr   = gate && !cfg_word[CFG_PWLK];
                end
                K_CHKPW: fin_pw_ok = (dat == pw_word);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= C_IDLE;
            sh          <= '0;
            nbits       <= '0;
            pw_ok       <= 1'b0;
            wrote       <= 1'b0;
            resp_after  <= 1'b0;
            gap_n       <= 1'b0;
            page_q      <= '0;
            mem_wr      <= 1'b0;
            mem_wr_page <= '0;
            mem_wr_data <= '0;
            resp_req    <= 1'b0;
            resp_page   <= '0;
            id_ret      <= 1'b0;
            cmd_off     <= 1'b0;
        end else begin
            mem_wr   <= 1'b0;
            resp_req <= 1'b0;
            id_ret   <= 1'b0;
            case (st)
                C_IDLE: if (start_det) begin
                    st    <= C_RX;
                    nbits <= '0;
                end
                C_RX: if (bit_err) begin
                    id_ret <= 1'b1;
                    st     <= C_IDLE;
                end else if (bit_stb) begin
                    sh    <= sh_n;
                    nbits <= nb;
                    if (nb == 6'(OP_BITS)) begin
                        case (kind6)
                            K_BAD: begin
                                id_ret <= 1'b1;
                                st     <= C_IDLE;
                            end
                            K_RDPAGE: if (gate) begin
                                st     <= C_GAP;
                                gap_n  <= 1'b0;
                                page_q <= {1'b0, sh_n[4:2]};
                            end else begin
                                id_ret <= 1'b1;
                                st     <= C_IDLE;
                            end
                            K_DIS: begin
                                cmd_off <= 1'b1;
                                st      <= C_IDLE;
                            end
                            default: ;
                        endcase
                    end else if (nb == 6'(CMD_BITS)) begin
                        if (fin_wr) begin
                            mem_wr      <= 1'b1;
                            mem_wr_page <= fin_page;
                            mem_wr_data <= fin_data;
                            page_q      <= fin_page;
                            resp_after  <= fin_resp;
                            st          <= C_WR;
                            if (kind == K_WRPAGE) wrote <= 1'b1;
                        end else begin
                            id_ret <= 1'b1;
                            st     <= C_IDLE;
                            if (fin_pw_ok) pw_ok <= 1'b1;
                        end
                    end
                end
                C_GAP: if (bit_end) begin
                    if (gap_n) begin
                        resp_req  <= 1'b1;
                        resp_page <= page_q;
                        st        <= C_IDLE;
                    end else begin
                        gap_n <= 1'b1;
                    end
                end
                C_WR: if (mem_wr_done) begin
                    if (resp_after) begin
                        resp_req  <= 1'b1;
                        resp_page <= page_q;
                    end else begin
                        id_ret <= 1'b1;
                    end
                    st <= C_IDLE;
                end
                default: st <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crx_cmd_ctrl.sv
module crx_cmd_ctrl
    import crx_pkg::*;
#(
    parameter int TX_UNIT = 16,
    parameter int TCLK_W  = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        win_start,
    input  logic        field_mod,
    input  logic [31:0] cfg_word,
    input  logic [31:0] pw_word,
    input  logic        mem_wr_done,
    output logic        mem_wr,
    output logic [3:0]  mem_wr_page,
    output logic [31:0] mem_wr_data,
    output logic        resp_req,
    output logic [3:0]  resp_page,
    output logic        id_ret,
    output logic        cmd_off
);
    logic start_det, bit_stb, bit_val, bit_err, bit_end, keep;

    crx_bit_decoder #(.TX_UNIT(TX_UNIT), .TCLK_W(TCLK_W)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .win_start (win_start && !cmd_off),
        .field_mod (field_mod),
        .tclk      (cfg_word[CFG_TCLK_LSB +: TCLK_W]),
        .rx_x4     (cfg_word[CFG_RX4]),
        .keep      (keep),
        .start_det (start_det),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .bit_err   (bit_err),
        .bit_end   (bit_end)
    );

    crx_access u_ctl (
        .clk         (clk),
        .rst         (rst),
        .start_det   (start_det),
        .bit_stb     (bit_stb),
        .bit_val     (bit_val),
        .bit_err     (bit_err),
        .bit_end     (bit_end),
        .cfg_word    (cfg_word),
        .pw_word     (pw_word),
        .mem_wr_done (mem_wr_done),
        .keep        (keep),
        .mem_wr      (mem_wr),
        .mem_wr_page (mem_wr_page),
        .mem_wr_data (mem_wr_data),
        .resp_req    (resp_req),
        .resp_page   (resp_page),
        .id_ret      (id_ret),
        .cmd_off     (cmd_off)
    );
endmodule

// File: rtl/crx_cmd_ctrl_chk.sv
module crx_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cfg_word,
    input logic        mem_wr,
    input logic [3:0]  mem_wr_page,
    input logic [31:0] mem_wr_data,
    input logic        resp_req,
    input logic [3:0]  resp_page,
    input logic        id_ret,
    input logic        cmd_off
);
    // R13: response and return-to-identity never in the same cycle
    p_one_event_r13: assert property (@(posedge clk) disable iff (rst)
        !(resp_req && id_ret));

    // R13: write request lasts one cycle
    p_wr_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

    // R11: password page is never sent out
    p_no_pw_send_r11: assert property (@(posedge clk) disable iff (rst)
        resp_req |-> (resp_page != 4'd9));

    // R6: serial page is never written
    p_serial_ro_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wr_page != 4'd7));

    // R6: user page write only when its lock bit was clear at decision time
    p_locked_page_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_wr_page < 4'd8) |->
            (($past(cfg_word[31:24]) & (8'd1 << mem_wr_page[2:0])) == 8'd0));

    // R7: page 8 writes keep every lock bit already set
    p_lock_or_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_wr_page == 4'd8) |->
            ((mem_wr_data[31:24] & $past(cfg_word[31:24])) == $past(cfg_word[31:24])));

    // R12: disable is sticky and silences the block
    p_off_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        cmd_off |=> cmd_off);
    p_off_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        cmd_off |=> !(mem_wr || resp_req || id_ret));
endmodule

bind crx_cmd_ctrl crx_cmd_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_word    (cfg_word),
    .mem_wr      (mem_wr),
    .mem_wr_page (mem_wr_page),
    .mem_wr_data (mem_wr_data),
    .resp_req    (resp_req),
    .resp_page   (resp_page),
    .id_ret      (id_ret),
    .cmd_off     (cmd_off)
);

// File: tb/crx_cmd_ctrl_tb.sv
module crx_cmd_ctrl_tb;
    localparam int TXU = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_start = 1'b0;
    logic        field_mod = 1'b0;
    logic        mem_wr_done = 1'b0;
    logic [31:0] mem [0:9];
    logic [31:0] cfg_word, pw_word;
    logic        mem_wr, resp_req, id_ret, cmd_off;
    logic [3:0]  mem_wr_page, resp_page;
    logic [31:0] mem_wr_data;

    int tests = 0, fails = 0;
    int n_resp = 0, n_id = 0, n_wr = 0, done_cnt = 0, cyc = 0;
    logic [3:0] last_page = '0;

    assign cfg_word = mem[8];
    assign pw_word  = mem[9];

    always #2.5 clk = ~clk;

    crx_cmd_ctrl #(.TX_UNIT(TXU), .TCLK_W(6)) u_dut (
        .clk(clk), .rst(rst), .win_start(win_start), .field_mod(field_mod),
        .cfg_word(cfg_word), .pw_word(pw_word), .mem_wr_done(mem_wr_done),
        .mem_wr(mem_wr), .mem_wr_page(mem_wr_page), .mem_wr_data(mem_wr_data),
        .resp_req(resp_req), .resp_page(resp_page), .id_ret(id_ret), .cmd_off(cmd_off)
    );

    // memory model and event monitor, away from the active edge
    always @(negedge clk) begin
        mem_wr_done <= (done_cnt == 1);
        if (done_cnt > 0) done_cnt = done_cnt - 1;
        if (!rst) begin
            if (resp_req) begin n_resp = n_resp + 1; last_page = resp_page; end
            if (id_ret) n_id = n_id + 1;
            if (mem_wr) begin
                n_wr = n_wr + 1;
                if (mem_wr_page <= 4'd9) mem[mem_wr_page] = mem_wr_data;
                done_cnt = 3;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: got %h exp %h", req, what, act, exp);
        end
    endtask

    function automatic int tx_b();
        return (int'(mem[8][13:8]) + 1) * TXU;
    endfunction
    function automatic int rx_b();
        return mem[8][7] ? tx_b() * 4 : tx_b() * 2;
    endfunction

    task automatic open_win();
        n_resp = 0; n_id = 0; n_wr = 0;
        @(negedge clk) win_start = 1'b1;
        @(negedge clk) win_start = 1'b0;
    endtask

    task automatic send_cmd(input logic [5:0] op, input bit has_d, input logic [31:0] d,
                            input bit bad_par, input int sb, input int err_b);
        logic [38:0] bits;
        int n, tx, rx;
        tx = tx_b(); rx = rx_b();
        n = has_d ? 39 : 6;
        bits = has_d ? {op, d, (^{op, d}) ^ bad_par} : {op, 33'b0};
        open_win();
        repeat (sb * tx) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            field_mod = (i == err_b) ? 1'b1 : !bits[38 - i];
            repeat (rx / 2) @(negedge clk);
            field_mod = (i == err_b) ? 1'b1 : bits[38 - i];
            repeat (rx / 2) @(negedge clk);
        end
        field_mod = 1'b0;
        repeat (rx * 3 + 60) @(negedge clk);
    endtask

    task automatic pulse_in_bit(input int b);
        int tx;
        tx = tx_b();
        open_win();
        repeat (b * tx) @(negedge clk);
        field_mod = 1'b1;
        repeat (tx) @(negedge clk);
        field_mod = 1'b0;
        repeat (16 * tx + 40) @(negedge clk);
    endtask

    task automatic expect_abort(input string req, input string what);
        chk(n_id == 1 && n_resp == 0 && n_wr == 0, req, what,
            {n_id[7:0], n_resp[7:0], n_wr[7:0], 8'h0}, 32'h0100_0000);
    endtask

    task automatic expect_resp(input string req, input string what, input logic [3:0] pg);
        chk(n_resp == 1 && n_id == 0 && last_page == pg, req, what,
            {n_resp[7:0], n_id[7:0], 12'h0, last_page}, {8'd1, 8'd0, 12'h0, pg});
    endtask

    initial begin
        logic [31:0] s;
        for (int k = 0; k < 8; k++) mem[k] = 32'hA5A5_0000 + k;
        mem[8] = 32'h8000_0000;
        mem[9] = 32'hCAFE_F00D;
        repeat (4) @(negedge clk);
        // R13: reset state
        chk({mem_wr, resp_req, id_ret, cmd_off} == 4'b0, "R13", "reset outputs",
            {28'h0, mem_wr, resp_req, id_ret, cmd_off}, 32'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R11, R3, R1: read page 3 starting in window bit 1
        send_cmd(6'b001101, 0, 0, 0, 1, -1);
        expect_resp("R11", "read page 3 at bit 1", 4'd3);
        // R3: start in window bit 6 accepted
        send_cmd(6'b010101, 0, 0, 0, 6, -1);
        expect_resp("R3", "read page 5 at bit 6", 4'd5);
        // R3: modulation in bit 0 and bit 7 ignored
        pulse_in_bit(0);
        chk(n_resp == 0 && n_id == 0, "R3", "bit 0 ignored", n_resp + n_id, 0);
        pulse_in_bit(7);
        chk(n_resp == 0 && n_id == 0, "R3", "bit 7 ignored", n_resp + n_id, 0);
        // R1: equal halves abort
        send_cmd(6'b000101, 0, 0, 0, 2, 2);
        expect_abort("R1", "encoding error");
        // R4: illegal opcode
        send_cmd(6'b001011, 1, 32'h0, 0, 2, -1);
        expect_abort("R4", "illegal code");
        // R7: lock before any page write
        send_cmd(6'b000011, 1, {8'h01, 24'h555555}, 0, 3, -1);
        expect_abort("R7", "lock without prior write");
        chk(mem[8] == 32'h8000_0000, "R7", "page 8 kept", mem[8], 32'h8000_0000);
        // R5: bad parity
        send_cmd(6'b001010, 1, 32'h1234_5678, 1, 2, -1);
        expect_abort("R5", "parity mismatch");
        chk(mem[2] == 32'hA5A5_0002, "R5", "page 2 kept", mem[2], 32'hA5A5_0002);
        // R6: good write
        send_cmd(6'b001010, 1, 32'h1234_5678, 0, 2, -1);
        expect_resp("R6", "write page 2 response", 4'd2);
        chk(mem[2] == 32'h1234_5678, "R6", "page 2 data", mem[2], 32'h1234_5678);
        // R6: serial page refused
        send_cmd(6'b011110, 1, 32'hFFFF_0000, 0, 2, -1);
        expect_abort("R6", "write page 7");
        chk(mem[7] == 32'hA5A5_0007, "R6", "page 7 kept", mem[7], 32'hA5A5_0007);
        // R7: bad filler
        send_cmd(6'b000011, 1, {8'h04, 24'h555554}, 0, 2, -1);
        expect_abort("R7", "lock filler error");
        // R7: lock page 2, then OR behaviour
        send_cmd(6'b000011, 1, {8'h04, 24'h555555}, 0, 2, -1);
        expect_resp("R7", "lock response", 4'd8);
        chk(mem[8] == 32'h8400_0000, "R7", "lock merged", mem[8], 32'h8400_0000);
        send_cmd(6'b000011, 1, {8'h00, 24'h555555}, 0, 2, -1);
        chk(mem[8] == 32'h8400_0000, "R7", "lock not cleared", mem[8], 32'h8400_0000);
        // R6: locked page refused
        send_cmd(6'b001010, 1, 32'h0000_0001, 0, 2, -1);
        expect_abort("R6", "locked page 2");
        chk(mem[2] == 32'h1234_5678, "R6", "locked page kept", mem[2], 32'h1234_5678);
        // R8: config filler error, then password mode on
        send_cmd(6'b010011, 1, {8'h54, 24'h004000}, 0, 2, -1);
        expect_abort("R8", "config filler error");
        send_cmd(6'b010011, 1, {8'h55, 24'h004000}, 0, 2, -1);
        expect_resp("R8", "config response", 4'd8);
        chk(mem[8] == 32'h8400_4000, "R8", "config data", mem[8], 32'h8400_4000);
        // R9: gated access
        send_cmd(6'b001101, 0, 0, 0, 2, -1);
        expect_abort("R9", "read before password");
        send_cmd(6'b011100, 1, 32'hCAFE_F00E, 0, 2, -1);
        chk(n_id == 1, "R9", "wrong check returns", n_id, 1);
        send_cmd(6'b001101, 0, 0, 0, 2, -1);
        expect_abort("R9", "read after wrong password");
        send_cmd(6'b011100, 1, 32'hCAFE_F00D, 0, 2, -1);
        chk(n_id == 1 && n_wr == 0, "R9", "good check returns", n_id, 1);
        send_cmd(6'b001101, 0, 0, 0, 2, -1);
        expect_resp("R9", "read after password", 4'd3);
        // R2: receive rate x4 with transmit divider 2
        send_cmd(6'b010011, 1, {8'h55, 24'h004180}, 0, 2, -1);
        chk(mem[8] == 32'h8400_4180, "R2", "rate config", mem[8], 32'h8400_4180);
        send_cmd(6'b010001, 0, 0, 0, 1, -1);
        expect_resp("R2", "read page 4 at slow rate", 4'd4);
        // R10: password write
        send_cmd(6'b000111, 1, 32'h0BAD_CAFE, 0, 2, -1);
        chk(mem[9] == 32'h0BAD_CAFE, "R10", "password data", mem[9], 32'h0BAD_CAFE);
        chk(n_id == 1 && n_resp == 0, "R10", "no response", n_resp, 0);
        // R8, R10: lock password and config
        send_cmd(6'b010011, 1, {8'h55, 24'h004183}, 0, 2, -1);
        chk(mem[8] == 32'h8400_4183, "R8", "locks set", mem[8], 32'h8400_4183);
        send_cmd(6'b000111, 1, 32'h0000_0001, 0, 2, -1);
        expect_abort("R10", "password locked");
        chk(mem[9] == 32'h0BAD_CAFE, "R10", "password kept", mem[9], 32'h0BAD_CAFE);
        s = mem[8];
        send_cmd(6'b010011, 1, {8'h55, 24'h000000}, 0, 2, -1);
        expect_abort("R8", "config locked");
        chk(mem[8] == s, "R8", "config kept", mem[8], s);
        // R12: disable
        send_cmd(6'b011000, 0, 0, 0, 2, -1);
        chk(cmd_off == 1'b1 && n_id == 0, "R12", "disabled", {31'h0, cmd_off}, 1);
        send_cmd(6'b001101, 0, 0, 0, 2, -1);
        chk(n_resp == 0 && n_id == 0 && n_wr == 0, "R12", "silent after disable",
            n_resp + n_id + n_wr, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule